// File: doc/BRIEF.md
# Event Frame Serializer

This block reads out one complete event of channel values once the upstream pipeline has delivered it. On an accepted start strobe it captures all channel values, the event tag and the port mode. It then sends a four-word header followed by the channel payload, spread over one, two or four output ports depending on the mode. Each port has its own data word and valid flag. A busy flag covers the frame, and a one-cycle done pulse marks its end.

There are three modes. In single-port mode every channel goes out in turn on port 0. In quad-port mode the channels are split into four equal contiguous slices, one per port. In binary mode, two ports each carry two hit bits per clock cycle, which is twice the per-port rate of the multi-bit modes. The two fast modes finish a 128-channel event in 36 cycles, which is 900 ns at a 40 MHz clock. Single-port mode takes longer.

The controller has four states. IDLE waits for a start. HEAD sends the header words. BODY sends the payload. DONE raises the done pulse for one cycle. The transitions are:
- IDLE to HEAD on an accepted start.
- HEAD to BODY after the fourth header word.
- BODY to DONE after the last payload word.
- DONE to HEAD when a start is accepted in that cycle, otherwise DONE to IDLE.

Top module: `evt_serializer`

## Requirements
- R1: After reset, busy, done and every port valid flag are low and every port data word is zero.
- R2: A start is accepted only in IDLE or DONE and only with mode code 00 (single), 01 (quad) or 10 (binary). In the four cycles after the accepting clock edge, every active port shows A5h, then the tag, then the 2-bit mode code zero-extended, then the bitwise inverse of the tag.
- R3: In single mode only port 0 is valid, and after the header it carries channels 0 to 127 in ascending order, one per cycle.
- R4: In quad mode all four ports are valid, and after the header port k carries channels 32k to 32k+31 in ascending order, one per cycle.
- R5: In binary mode ports 0 and 1 are valid. In payload cycle i, port j carries bit 0 of channel 64j+2i in data bit 0 and bit 0 of channel 64j+2i+1 in data bit 1, with all higher bits zero, for 32 cycles.
- R6: Quad and binary frames last at most 36 cycles from the first header word to the last payload word.
- R7: Busy is high exactly from the first header word through the last payload word. Valid is never high while busy is low.
- R8: Done is high for exactly one cycle, the cycle right after the last payload word.
- R9: A start while busy is ignored, and the frame in progress continues unchanged.
- R10: A start with mode code 11 is ignored: busy and all valid flags stay low.
- R11: Channel values, tag and mode are captured when the start is accepted. Input changes during a frame have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for one frame |
| mode_i | input | 2 | Port mode: 00 single, 01 quad, 10 binary |
| tag_i | input | 8 | Event tag placed in the header |
| chan_i | input | 128x8 | Channel values of the event |
| port_data_o | output | 4x8 | Data word on each output port |
| port_valid_o | output | 4 | Valid flag on each output port |
| busy_o | output | 1 | High while a frame is being sent |
| done_o | output | 1 | One-cycle pulse after the frame ends |

## Verification
The hardest situation to reach from the ports is a start strobe arriving in the middle of a frame together with new channel values, a new tag and a new mode. Every one of these must be shut out by the captured copies and by the busy gate. The directed scenario raises start in payload cycle 10. At the same time it inverts every channel value and the tag and changes the mode. The bench then checks each remaining word against the copy of the inputs saved at the accepted start. It also checks that no second frame follows the done pulse.

// File: rtl/evs_pkg.sv
package evs_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_QUAD   = 2'b01,
        MODE_BIN    = 2'b10,
        MODE_RSVD   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_HEAD,
        S_BODY,
        S_DONE
    } st_e;

    localparam int HDR_LEN = 4;
    localparam logic [7:0] SYNC_WORD = 8'hA5;

endpackage

// File: rtl/evs_fsm.sv
module evs_fsm
    import evs_pkg::*;
#(
    parameter int NCH = 128,
    parameter int NQ  = 4,
    parameter int NB  = 2,
    parameter int CW  = $clog2(NCH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    mode_i,
    output st_e           st_q,
    output logic [CW-1:0] cnt_q,
    output mode_e         mode_q,
    output logic          load_o
);
    localparam int LEN_S = NCH;
    localparam int LEN_Q = NCH / NQ;
    localparam int LEN_B = NCH / (2 * NB);

    st_e           st_d;
    logic [CW-1:0] cnt_d;
    logic [CW-1:0] last_idx;
    logic          accept;

    always_comb begin
        unique case (mode_q)
            MODE_QUAD: last_idx = CW'(LEN_Q - 1);
            MODE_BIN:  last_idx = CW'(LEN_B - 1);
            default:   last_idx = CW'(LEN_S - 1);
        endcase
    end

    assign accept = start_i && (mode_i != MODE_RSVD) &&
                    ((st_q == S_IDLE) || (st_q == S_DONE));
    assign load_o = accept;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            S_IDLE: begin
                if (accept) begin
                    st_d  = S_HEAD;
                    cnt_d = '0;
                end
            end
            S_HEAD: begin
                if (cnt_q == CW'(HDR_LEN - 1)) begin
                    st_d  = S_BODY;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            S_BODY: begin
                if (cnt_q == last_idx) begin
                    st_d  = S_DONE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            S_DONE: begin
                st_d  = accept ? S_HEAD : S_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            cnt_q  <= '0;
            mode_q <= MODE_SINGLE;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (accept) begin
                mode_q <= mode_e'(mode_i);
            end
        end
    end

endmodule

// File: rtl/evs_lane.sv
module evs_lane
    import evs_pkg::*;
#(
    parameter int P   = 0,
    parameter int NCH = 128,
    parameter int DW  = 8,
    parameter int TW  = 8,
    parameter int NQ  = 4,
    parameter int NB  = 2,
    parameter int CW  = $clog2(NCH + 1)
) (
    input  st_e                     st_q,
    input  logic [CW-1:0]           cnt_q,
    input  mode_e                   mode_q,
    input  logic [TW-1:0]           tag_q,
    input  logic [NCH-1:0][DW-1:0]  snap_q,
    output logic                    vld_o,
    output logic [DW-1:0]           dat_o
);
    localparam int IW     = $clog2(NCH);
    localparam int SLICE  = NCH / NQ;
    localparam int SPAN_B = NCH / NB;

    logic [DW-1:0] qword;
    logic [DW-1:0] bword;
    logic [DW-1:0] sword;
    logic          act;

    assign sword = snap_q[cnt_q[IW-1:0]];

    generate
        if (P < NQ) begin : g_quad
            logic [IW-1:0] qidx;
            assign qidx  = IW'(P * SLICE) + cnt_q[IW-1:0];
            assign qword = snap_q[qidx];
        end else begin : g_noquad
            assign qword = '0;
        end

        if (P < NB) begin : g_bin
            logic [IW-1:0] bidx0;
            logic [IW-1:0] bidx1;
            assign bidx0 = IW'(P * SPAN_B) + {cnt_q[IW-2:0], 1'b0};
            assign bidx1 = bidx0 | IW'(1);
            assign bword = DW'({snap_q[bidx1][0], snap_q[bidx0][0]});
        end else begin : g_nobin
            assign bword = '0;
        end
    endgenerate

    always_comb begin
        unique case (mode_q)
            MODE_SINGLE: act = (P == 0);
            MODE_QUAD:   act = (P < NQ);
            MODE_BIN:    act = (P < NB);
            default:     act = 1'b0;
        endcase
    end

    always_comb begin
        vld_o = act && ((st_q == S_HEAD) || (st_q == S_BODY));
        dat_o = '0;
        if (vld_o) begin
            if (st_q == S_HEAD) begin
                unique case (cnt_q[1:0])
                    2'd0: dat_o = DW'(SYNC_WORD);
                    2'd1: dat_o = DW'(tag_q);
                    2'd2: dat_o = DW'(mode_q);
                    2'd3: dat_o = DW'(~tag_q);
                endcase
            end else begin
                unique case (mode_q)
                    MODE_QUAD: dat_o = qword;
                    MODE_BIN:  dat_o = bword;
                    default:   dat_o = sword;
                endcase
            end
        end
    end

endmodule

// File: rtl/evt_serializer.sv
module evt_serializer
    import evs_pkg::*;
#(
    parameter int NCH = 128,
    parameter int DW  = 8,
    parameter int TW  = 8,
    parameter int NQ  = 4,
    parameter int NB  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [1:0]             mode_i,
    input  logic [TW-1:0]          tag_i,
    input  logic [NCH-1:0][DW-1:0] chan_i,
    output logic [NQ-1:0][DW-1:0]  port_data_o,
    output logic [NQ-1:0]          port_valid_o,
    output logic                   busy_o,
    output logic                   done_o
);
    localparam int CW = $clog2(NCH + 1);

    st_e                    st_q;
    logic [CW-1:0]          cnt_q;
    mode_e                  mode_q;
    logic                   load;
    logic [TW-1:0]          tag_q;
    logic [NCH-1:0][DW-1:0] snap_q;

    evs_fsm #(.NCH(NCH), .NQ(NQ), .NB(NB), .CW(CW)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .mode_i (mode_i),
        .st_q   (st_q),
        .cnt_q  (cnt_q),
        .mode_q (mode_q),
        .load_o (load)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            snap_q <= '0;
        end else if (load) begin
            tag_q  <= tag_i;
            snap_q <= chan_i;
        end
    end

    generate
        for (genvar p = 0; p < NQ; p++) begin : g_lane
            evs_lane #(
                .P(p), .NCH(NCH), .DW(DW), .TW(TW),
                .NQ(NQ), .NB(NB), .CW(CW)
            ) u_lane (
                .st_q  (st_q),
                .cnt_q (cnt_q),
                .mode_q(mode_q),
                .tag_q (tag_q),
                .snap_q(snap_q),
                .vld_o (port_valid_o[p]),
                .dat_o (port_data_o[p])
            );
        end
    endgenerate

    always_comb begin
        busy_o = (st_q == S_HEAD) || (st_q == S_BODY);
        done_o = (st_q == S_DONE);
    end

endmodule

// File: rtl/evs_chk.sv
module evs_chk #(
    parameter int NQ = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [1:0]    mode_i,
    input logic [NQ-1:0] port_valid_o,
    input logic          busy_o,
    input logic          done_o
);
    // R8
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R7
    valid_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_valid_o) |-> busy_o);

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(start_i) && ($past(mode_i) != 2'b11)));

    // R10
    valid_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(port_valid_o) inside {0, 1, 2, NQ});

    // R3
    valid_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_valid_o) |-> port_valid_o[0]);

endmodule

bind evt_serializer evs_chk #(.NQ(NQ)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .port_valid_o(port_valid_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/evt_serializer_test.sv
module evt_serializer_test;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 start_i;
    logic [1:0]           mode_i;
    logic [7:0]           tag_i;
    logic [127:0][7:0]    chan_i;
    logic [3:0][7:0]      port_data_o;
    logic [3:0]           port_valid_o;
    logic                 busy_o;
    logic                 done_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    evt_serializer uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .tag_i(tag_i), .chan_i(chan_i), .port_data_o(port_data_o),
        .port_valid_o(port_valid_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 128; i++) chan_i[i] = 8'((i * 37 + seed * 11 + (i >> 3)) & 8'hFF);
    endtask

    function automatic int body_len(input int mode);
        return (mode == 0) ? 128 : 32;
    endfunction

    function automatic logic [39:0] exp_vec(input int mode, input logic [7:0] tag,
                                            input logic [127:0][7:0] s, input int k);
        logic [3:0]      v = '0;
        logic [3:0][7:0] d = '0;
        v = (mode == 0) ? 4'b0001 : (mode == 1) ? 4'b1111 : 4'b0011;
        for (int p = 0; p < 4; p++) begin
            if (v[p]) begin
                if (k < 4) begin
                    d[p] = (k == 0) ? 8'hA5 : (k == 1) ? tag : (k == 2) ? 8'(mode) : ~tag;
                end else begin
                    int i = k - 4;
                    if (mode == 0)      d[p] = s[i];
                    else if (mode == 1) d[p] = s[32 * p + i];
                    else d[p] = {6'b0, s[64 * p + 2 * i + 1][0], s[64 * p + 2 * i][0]};
                end
            end
        end
        return {v, d};
    endfunction

    // One frame; optional disturbance at payload cycle (inject_k) for R9 and R11.
    task automatic run_frame(input int mode, input logic [7:0] tag,
                             input int inject_k, input string req);
        logic [127:0][7:0] snap = chan_i;
        int len  = 4 + body_len(mode);
        int busy_cycles = 0;
        @(negedge clk);
        mode_i  = 2'(mode);
        tag_i   = tag;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < len; k++) begin
            logic [39:0] e = exp_vec(mode, tag, snap, k);
            start_i = 1'b0;
            check({port_valid_o, port_data_o} == e, req, $sformatf("word %0d", k),
                  64'({port_valid_o, port_data_o}), 64'(e));
            // R7 busy through the frame, no done
            check(busy_o && !done_o, "R7", $sformatf("busy word %0d", k),
                  64'({busy_o, done_o}), 64'b10);
            if (busy_o) busy_cycles++;
            if (k == inject_k) begin
                // R9 R11 disturb inputs mid-frame
                start_i = 1'b1;
                tag_i   = ~tag;
                mode_i  = (mode == 1) ? 2'd0 : 2'd1;
                for (int i = 0; i < 128; i++) chan_i[i] = ~chan_i[i];
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        // R8 done one cycle after last word
        check(done_o && !busy_o && port_valid_o == 4'b0, "R8", "done cycle",
              64'({done_o, busy_o, port_valid_o}), 64'b1_0_0000);
        if (mode != 0)  // R6 budget of 36 cycles
            check(busy_cycles <= 36, "R6", "frame length", 64'(busy_cycles), 64'd36);
        @(negedge clk);
        check(!done_o && !busy_o, "R8", "after done",
              64'({done_o, busy_o}), 64'b00);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; start_i = 1'b0; mode_i = 2'd0; tag_i = 8'h00; fill(1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!busy_o && !done_o && port_valid_o == 4'b0 && port_data_o == '0,
              "R1", "reset state", 64'({busy_o, done_o, port_valid_o, port_data_o}), 64'd0);
    endtask

    task automatic t_single;
        fill(2);
        run_frame(0, 8'h3C, -1, "R3");
    endtask

    task automatic t_quad;
        fill(3);
        run_frame(1, 8'h81, -1, "R4");
    endtask

    task automatic t_binary;
        fill(4);
        run_frame(2, 8'hE7, -1, "R5");
    endtask

    task automatic t_header;
        fill(5);
        run_frame(1, 8'h5A, -1, "R2");
    endtask

    task automatic t_busy_start;
        fill(6);
        run_frame(1, 8'h96, 14, "R9");
        fill(7);
        run_frame(2, 8'h11, 20, "R11");
    endtask

    task automatic t_reserved;
        @(negedge clk);
        mode_i = 2'b11; tag_i = 8'h22; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            // R10 reserved mode ignored
            check(!busy_o && port_valid_o == 4'b0, "R10", $sformatf("rsvd cycle %0d", k),
                  64'({busy_o, port_valid_o}), 64'd0);
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        t_reset();
        t_header();
        t_single();
        t_quad();
        t_binary();
        t_busy_start();
        t_reserved();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule